// File: doc/BRIEF.md
# Blob Descriptor Accumulation Engine

This engine reduces one binary blob to a handful of integer shape descriptors in a single raster sweep over the blob's region of interest (ROI). A controller pulses `start` together with the ROI origin and size. It then streams the ROI's pixel bits, column index running fastest, using a valid qualifier. Idle cycles may appear between pixels. No frame memory is needed: two line registers plus the line being received are enough to form every 2x2 neighbourhood and every 4-neighbour test.

When the last ROI pixel has been taken, the engine raises `done`. It then presents the following results:

- the foreground pixel count;
- the sums of the absolute x and y coordinates of the foreground pixels, which software divides by the area to obtain the centre;
- a boundary-pixel count used as a preliminary perimeter;
- the Euler number.

All arithmetic is short-integer addition driven by small lookup functions. The results stay frozen until the next `start`. The connectivity used for the Euler number is chosen at elaboration time.

Top module: `blob_accum`

## Requirements
- R1: After reset `busy`, `done` and all descriptor outputs are zero. A `start` pulse clears all descriptors, drops `done` and raises `busy` at the same clock edge, and latches `roi_x0`, `roi_y0`, `roi_w`, `roi_h`.
- R2: `area` equals the number of accepted pixels whose `pix_fg` is 1.
- R3: `sum_x` and `sum_y` equal the sums over foreground pixels of `roi_x0 + col` and `roi_y0 + row`. Here `col` and `row` are the pixel's zero-based position in the ROI, and `roi_x0 + roi_w` and `roi_y0 + roi_h` must not exceed 2^COORD_W.
- R4: `perimeter` counts the foreground pixels that have at least one of their left, right, upper or lower neighbours in the background. Positions outside the ROI count as background.
- R5: The 2x2 windows of the ROI padded by a ring of background pixels are classified by their foreground count. Q1 is the number of windows with exactly one foreground pixel, Q3 the number with exactly three, and QD the number whose two foreground pixels lie on a diagonal. `euler` is a two's-complement value equal to (Q1 - Q3 + 2*QD)/4 when EULER_CONN is 4, and (Q1 - Q3 - 2*QD)/4 when it is 8.
- R6: `done` rises, and `busy` falls, at the clock edge that accepts the pixel at column `roi_w-1` of row `roi_h-1`. While `done` is high and no `start` arrives, `done` and every descriptor hold their values.
- R7: A pixel is accepted only at an edge where `pix_valid` and `busy` are both high. A pixel offered while the engine is not busy has no effect on any descriptor.
- R8: Pixels are taken in raster order, column fastest, and any number of idle cycles between pixels leaves the results unchanged. ROI sizes run from 1x1 to MAX_W x MAX_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep and latch ROI bounds |
| roi_x0 | input | COORD_W | Absolute column of the ROI's left edge |
| roi_y0 | input | COORD_W | Absolute row of the ROI's top edge |
| roi_w | input | clog2(MAX_W+1) | ROI width in pixels, 1..MAX_W |
| roi_h | input | clog2(MAX_H+1) | ROI height in pixels, 1..MAX_H |
| pix_valid | input | 1 | Pixel qualifier |
| pix_fg | input | 1 | Pixel bit, 1 = foreground |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Descriptors complete and held |
| area | output | AREA_W | Foreground pixel count |
| sum_x | output | COORD_W+AREA_W | Sum of absolute x of foreground pixels |
| sum_y | output | COORD_W+AREA_W | Sum of absolute y of foreground pixels |
| perimeter | output | AREA_W | Count of boundary foreground pixels |
| euler | output | AREA_W+1 | Signed Euler number |

## Verification
Every descriptor is registered at the edge that accepts a pixel. The final values and `done` are therefore due one edge after the last pixel is taken, and the first ROI line's boundary contributions arrive one line late without changing that deadline. The bench drives inputs on falling edges. It reads `done` once on the falling edge just before the last pixel's rising edge, where it must still be low. It then reads every output on the falling edge that follows. The `start` effects are checked one falling edge after the pulse, and the idle-pixel test reads the outputs after several offered cycles while the engine is not busy.

// File: rtl/blob_desc_pkg.sv
`timescale 1ns/1ps
package blob_desc_pkg;

   typedef enum logic [1:0] {
      QK_NONE  = 2'd0,
      QK_ONE   = 2'd1,
      QK_THREE = 2'd2,
      QK_DIAG  = 2'd3
   } quad_kind_t;

   // Window bits are ordered {top_left, top_right, bottom_left, bottom_right}.
   function automatic quad_kind_t classify_quad(input logic [3:0] q);
      quad_kind_t k;
      case (q)
         4'b0001, 4'b0010, 4'b0100, 4'b1000: k = QK_ONE;
         4'b0111, 4'b1011, 4'b1101, 4'b1110: k = QK_THREE;
         4'b1001, 4'b0110:                   k = QK_DIAG;
         default:                            k = QK_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/blob_raster_ctl.sv
`timescale 1ns/1ps
module blob_raster_ctl #(
   parameter int MAX_W = 64,
   parameter int MAX_H = 64,
   localparam int WW = $clog2(MAX_W + 1),
   localparam int HW = $clog2(MAX_H + 1),
   localparam int CW = $clog2(MAX_W),
   localparam int RW = $clog2(MAX_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [WW-1:0] roi_w,
   input  logic [HW-1:0] roi_h,
   input  logic          pix_valid,
   output logic          busy,
   output logic          done,
   output logic          take,
   output logic [CW-1:0] col,
   output logic [RW-1:0] row,
   output logic          last_col,
   output logic          last_row
);

   logic [CW-1:0] col_q, col_end_q;
   logic [RW-1:0] row_q, row_end_q;
   logic          busy_q, done_q;

   assign take     = busy_q & pix_valid;
   assign col      = col_q;
   assign row      = row_q;
   assign last_col = (col_q == col_end_q);
   assign last_row = (row_q == row_end_q);
   assign busy     = busy_q;
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q     <= '0;
         row_q     <= '0;
         col_end_q <= '0;
         row_end_q <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
      end else if (start) begin
         col_q     <= '0;
         row_q     <= '0;
         col_end_q <= CW'(roi_w - WW'(1));
         row_end_q <= RW'(roi_h - HW'(1));
         busy_q    <= 1'b1;
         done_q    <= 1'b0;
      end else if (take) begin
         if (last_col) begin
            col_q <= '0;
            if (last_row) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               row_q <= row_q + RW'(1);
            end
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/blob_line_store.sv
`timescale 1ns/1ps
module blob_line_store #(
   parameter int MAX_W = 64,
   localparam int CW = $clog2(MAX_W),
   localparam int EW = $clog2(MAX_W + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          take,
   input  logic          line_end,
   input  logic [CW-1:0] col,
   input  logic          fg,
   output logic          nb_up,      // line two back, same column
   output logic          nb_left,    // previous line, column - 1
   output logic          nb_ctr,     // previous line, same column
   output logic          nb_right,   // previous line, column + 1
   output logic          cur_left    // current line, column - 1
);

   logic [MAX_W-1:0] line_cur_q, line_prev_q, line_old_q;
   logic [MAX_W-1:0] line_cur_nx;
   logic [MAX_W+1:0] prev_ext;
   logic [MAX_W:0]   cur_ext;
   logic [EW-1:0]    ix;

   // Zero padding on both sides turns out-of-ROI neighbours into background.
   assign prev_ext = {1'b0, line_prev_q, 1'b0};
   assign cur_ext  = {line_cur_q, 1'b0};
   assign ix       = EW'(col);

   assign nb_left  = prev_ext[ix];
   assign nb_ctr   = prev_ext[ix + EW'(1)];
   assign nb_right = prev_ext[ix + EW'(2)];
   assign cur_left = cur_ext[ix];
   assign nb_up    = line_old_q[col];

   always_comb begin
      line_cur_nx      = line_cur_q;
      line_cur_nx[col] = fg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cur_q  <= '0;
         line_prev_q <= '0;
         line_old_q  <= '0;
      end else if (clear) begin
         line_cur_q  <= '0;
         line_prev_q <= '0;
         line_old_q  <= '0;
      end else if (take) begin
         line_cur_q <= line_cur_nx;
         if (line_end) begin
            line_prev_q <= line_cur_nx;
            line_old_q  <= line_prev_q;
         end
      end
   end

endmodule

// File: rtl/blob_quad_euler.sv
`timescale 1ns/1ps
module blob_quad_euler
   import blob_desc_pkg::*;
#(
   parameter int CONN = 4
) (
   input  logic              q_tl,
   input  logic              q_tr,
   input  logic              q_bl,
   input  logic              fg,
   input  logic              last_col,
   input  logic              last_row,
   output logic signed [4:0] delta
);

   logic signed [4:0] diag_w;

   generate
      if (CONN == 8) begin : g_conn8
         assign diag_w = -5'sd2;
      end else begin : g_conn4
         assign diag_w = 5'sd2;
      end
   endgenerate

   function automatic logic signed [4:0] weigh(input logic [3:0] q,
                                               input logic signed [4:0] dw);
      logic signed [4:0] w;
      case (classify_quad(q))
         QK_ONE:   w = 5'sd1;
         QK_THREE: w = -5'sd1;
         QK_DIAG:  w = dw;
         default:  w = 5'sd0;
      endcase
      return w;
   endfunction

   logic signed [4:0] w_main, w_right, w_bot, w_corner;

   always_comb begin
      // window ending at the current pixel
      w_main   = weigh({q_tl, q_tr, q_bl, fg}, diag_w);
      // padding column right of the ROI
      w_right  = last_col ? weigh({q_tr, 1'b0, fg, 1'b0}, diag_w) : 5'sd0;
      // padding line below the ROI
      w_bot    = last_row ? weigh({q_bl, fg, 1'b0, 1'b0}, diag_w) : 5'sd0;
      // bottom-right padding corner
      w_corner = (last_row && last_col) ? weigh({fg, 1'b0, 1'b0, 1'b0}, diag_w) : 5'sd0;
      delta    = w_main + w_right + w_bot + w_corner;
   end

endmodule

// File: rtl/blob_accum.sv
`timescale 1ns/1ps
module blob_accum #(
   parameter int MAX_W     = 64,
   parameter int MAX_H     = 64,
   parameter int COORD_W   = 12,
   parameter int EULER_CONN = 4,
   localparam int WW     = $clog2(MAX_W + 1),
   localparam int HW     = $clog2(MAX_H + 1),
   localparam int AREA_W = $clog2(MAX_W * MAX_H + 1),
   localparam int SUM_W  = COORD_W + AREA_W,
   localparam int EUL_W  = AREA_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [COORD_W-1:0]      roi_x0,
   input  logic [COORD_W-1:0]      roi_y0,
   input  logic [WW-1:0]           roi_w,
   input  logic [HW-1:0]           roi_h,
   input  logic                    pix_valid,
   input  logic                    pix_fg,
   output logic                    busy,
   output logic                    done,
   output logic [AREA_W-1:0]       area,
   output logic [SUM_W-1:0]        sum_x,
   output logic [SUM_W-1:0]        sum_y,
   output logic [AREA_W-1:0]       perimeter,
   output logic signed [EUL_W-1:0] euler
);

   localparam int CW    = $clog2(MAX_W);
   localparam int RW    = $clog2(MAX_H);
   localparam int ACC_W = AREA_W + 3;

   generate
      if (MAX_W < 2 || MAX_H < 2) begin : g_bad_dim
         $error("blob_accum: MAX_W and MAX_H must be at least 2");
      end
      if (COORD_W < CW || COORD_W < RW) begin : g_bad_coord
         $error("blob_accum: COORD_W too narrow for the ROI dimensions");
      end
      if (EULER_CONN != 4 && EULER_CONN != 8) begin : g_bad_conn
         $error("blob_accum: EULER_CONN must be 4 or 8");
      end
   endgenerate

   logic          take, last_col, last_row;
   logic [CW-1:0] col;
   logic [RW-1:0] row;
   logic          nb_up, nb_left, nb_ctr, nb_right, cur_left;
   logic signed [4:0] e_delta;

   blob_raster_ctl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) ctl_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .roi_w(roi_w), .roi_h(roi_h), .pix_valid(pix_valid),
      .busy(busy), .done(done), .take(take),
      .col(col), .row(row), .last_col(last_col), .last_row(last_row)
   );

   blob_line_store #(.MAX_W(MAX_W)) lines_i (
      .clk(clk), .rst_n(rst_n), .clear(start), .take(take),
      .line_end(last_col), .col(col), .fg(pix_fg),
      .nb_up(nb_up), .nb_left(nb_left), .nb_ctr(nb_ctr),
      .nb_right(nb_right), .cur_left(cur_left)
   );

   blob_quad_euler #(.CONN(EULER_CONN)) quad_i (
      .q_tl(nb_left), .q_tr(nb_ctr), .q_bl(cur_left), .fg(pix_fg),
      .last_col(last_col), .last_row(last_row), .delta(e_delta)
   );

   // Boundary test for the pixel one line above (its lower neighbour is
   // arriving now); pixels of the final line always touch the outside.
   logic          edge_above, edge_here;
   logic [1:0]    perim_inc;
   logic [COORD_W-1:0] x0_q, y0_q, abs_x, abs_y;

   assign edge_above = (row != '0) && nb_ctr && !(nb_up && pix_fg && nb_left && nb_right);
   assign edge_here  = last_row && pix_fg;
   assign perim_inc  = {1'b0, edge_above} + {1'b0, edge_here};
   assign abs_x      = x0_q + COORD_W'(col);
   assign abs_y      = y0_q + COORD_W'(row);

   logic [AREA_W-1:0]       area_q, perim_q;
   logic [SUM_W-1:0]        sx_q, sy_q;
   logic signed [ACC_W-1:0] e4_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x0_q    <= '0;
         y0_q    <= '0;
         area_q  <= '0;
         perim_q <= '0;
         sx_q    <= '0;
         sy_q    <= '0;
         e4_q    <= '0;
      end else if (start) begin
         x0_q    <= roi_x0;
         y0_q    <= roi_y0;
         area_q  <= '0;
         perim_q <= '0;
         sx_q    <= '0;
         sy_q    <= '0;
         e4_q    <= '0;
      end else if (take) begin
         perim_q <= perim_q + AREA_W'(perim_inc);
         e4_q    <= e4_q + {{(ACC_W-5){e_delta[4]}}, e_delta};
         if (pix_fg) begin
            area_q <= area_q + AREA_W'(1);
            sx_q   <= sx_q + SUM_W'(abs_x);
            sy_q   <= sy_q + SUM_W'(abs_y);
         end
      end
   end

   logic signed [ACC_W-1:0] e_div;
   assign e_div     = e4_q >>> 2;
   assign euler     = e_div[EUL_W-1:0];
   assign area      = area_q;
   assign perimeter = perim_q;
   assign sum_x     = sx_q;
   assign sum_y     = sy_q;

endmodule

// File: rtl/blob_accum_chk.sv
`timescale 1ns/1ps
module blob_accum_chk #(
   parameter int AREA_W = 13,
   parameter int SUM_W  = 25,
   parameter int EUL_W  = 14
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    pix_valid,
   input logic                    pix_fg,
   input logic                    busy,
   input logic                    done,
   input logic [AREA_W-1:0]       area,
   input logic [AREA_W-1:0]       perimeter,
   input logic [SUM_W-1:0]        sum_x,
   input logic [SUM_W-1:0]        sum_y,
   input logic signed [EUL_W-1:0] euler
);

   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (area == '0 && perimeter == '0 && sum_x == '0 && busy && !done));

   p_area_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (area == $past(area) || area == $past(area) + AREA_W'(1)));

   p_area_bg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && !(pix_valid && pix_fg)) |=> ($stable(area) && $stable(sum_x) && $stable(sum_y)));

   p_perim_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      perimeter <= area);

   p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(area) && $stable(perimeter) && $stable(sum_x)
                            && $stable(sum_y) && $stable(euler)));

   p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(area) && $stable(perimeter) && $stable(euler) && !busy));

endmodule

bind blob_accum blob_accum_chk #(.AREA_W(AREA_W), .SUM_W(SUM_W), .EUL_W(EUL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid), .pix_fg(pix_fg),
   .busy(busy), .done(done), .area(area), .perimeter(perimeter),
   .sum_x(sum_x), .sum_y(sum_y), .euler(euler)
);

// File: tb/blob_accum_tb_top.sv
`timescale 1ns/1ps
module blob_accum_tb_top;

   localparam int MAX_W   = 64;
   localparam int MAX_H   = 64;
   localparam int COORD_W = 12;
   localparam int WW      = $clog2(MAX_W + 1);
   localparam int HW      = $clog2(MAX_H + 1);
   localparam int AREA_W  = $clog2(MAX_W * MAX_H + 1);
   localparam int SUM_W   = COORD_W + AREA_W;
   localparam int EUL_W   = AREA_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [COORD_W-1:0] roi_x0 = '0, roi_y0 = '0;
   logic [WW-1:0] roi_w = '0;
   logic [HW-1:0] roi_h = '0;
   logic pix_valid = 1'b0, pix_fg = 1'b0;
   logic busy, done;
   logic [AREA_W-1:0] area, perimeter;
   logic [SUM_W-1:0] sum_x, sum_y;
   logic signed [EUL_W-1:0] euler;

   always #5 clk = ~clk;

   blob_accum #(.MAX_W(MAX_W), .MAX_H(MAX_H), .COORD_W(COORD_W), .EULER_CONN(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .roi_x0(roi_x0), .roi_y0(roi_y0),
      .roi_w(roi_w), .roi_h(roi_h), .pix_valid(pix_valid), .pix_fg(pix_fg),
      .busy(busy), .done(done), .area(area), .sum_x(sum_x), .sum_y(sum_y),
      .perimeter(perimeter), .euler(euler)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;
   bit img [MAX_H][MAX_W];
   longint ex_area, ex_sx, ex_sy, ex_perim, ex_euler;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit px(int x, int y, int w, int h);
      if (x < 0 || y < 0 || x >= w || y >= h) return 1'b0;
      return img[y][x];
   endfunction

   task automatic reference(input int w, input int h, input int x0, input int y0);
      longint s4;
      ex_area = 0; ex_sx = 0; ex_sy = 0; ex_perim = 0; s4 = 0;
      for (int y = 0; y < h; y++)
         for (int x = 0; x < w; x++)
            if (img[y][x]) begin
               ex_area++;
               ex_sx += x0 + x;
               ex_sy += y0 + y;
               if (!px(x-1,y,w,h) || !px(x+1,y,w,h) || !px(x,y-1,w,h) || !px(x,y+1,w,h))
                  ex_perim++;
            end
      for (int ty = -1; ty < h; ty++)
         for (int tx = -1; tx < w; tx++) begin
            bit a, b, c, d;
            int n;
            a = px(tx,ty,w,h); b = px(tx+1,ty,w,h);
            c = px(tx,ty+1,w,h); d = px(tx+1,ty+1,w,h);
            n = int'(a) + int'(b) + int'(c) + int'(d);
            if (n == 1) s4 += 1;
            else if (n == 3) s4 -= 1;
            else if (n == 2 && ((a && d) || (b && c))) s4 += 2;
         end
      ex_euler = s4 / 4;
   endtask

   task automatic clear_img();
      for (int y = 0; y < MAX_H; y++)
         for (int x = 0; x < MAX_W; x++)
            img[y][x] = 1'b0;
   endtask

   task automatic run_frame(input int w, input int h, input int x0, input int y0,
                            input int gap_pct, input string tag);
      reference(w, h, x0, y0);
      @(negedge clk);
      start = 1'b1; roi_x0 = COORD_W'(x0); roi_y0 = COORD_W'(y0);
      roi_w = WW'(w); roi_h = HW'(h);
      @(negedge clk);
      start = 1'b0;
      // R1: start clears and arms
      check(busy && !done && area == 0 && perimeter == 0, "R1", {tag, " start state"},
            longint'({busy, done}), 2);
      for (int y = 0; y < h; y++)
         for (int x = 0; x < w; x++) begin
            while ($urandom_range(99) < gap_pct) begin
               pix_valid = 1'b0;
               pix_fg = 1'b1;
               @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_fg = img[y][x];
            if (x == w-1 && y == h-1)
               check(!done, "R6", {tag, " done early"}, longint'(done), 0);
            @(negedge clk);
         end
      pix_valid = 1'b0;
      pix_fg = 1'b0;
      check(done && !busy, "R6", {tag, " done after last pixel"}, longint'({done, busy}), 2);
      check(longint'(area) == ex_area, "R2", {tag, " area"}, longint'(area), ex_area);
      check(longint'(sum_x) == ex_sx, "R3", {tag, " sum_x"}, longint'(sum_x), ex_sx);
      check(longint'(sum_y) == ex_sy, "R3", {tag, " sum_y"}, longint'(sum_y), ex_sy);
      check(longint'(perimeter) == ex_perim, "R4", {tag, " perimeter"}, longint'(perimeter), ex_perim);
      check(longint'(euler) == ex_euler, "R5", {tag, " euler"}, longint'(euler), ex_euler);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && area == 0 && perimeter == 0 && sum_x == 0 && euler == 0,
            "R1", "reset state", longint'({busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // single pixel
      clear_img(); img[0][0] = 1;
      run_frame(1, 1, 100, 200, 0, "single");

      // ring with a hole: R5 euler 0, R4 perimeter 8
      clear_img();
      for (int y = 1; y <= 3; y++) for (int x = 1; x <= 3; x++) img[y][x] = 1;
      img[2][2] = 0;
      run_frame(5, 5, 7, 9, 0, "ring");

      // diagonal pair: R5 gives 2 for 4-connectivity
      clear_img(); img[0][0] = 1; img[1][1] = 1;
      run_frame(2, 2, 0, 0, 0, "diag");

      // solid square
      clear_img();
      for (int y = 0; y < 4; y++) for (int x = 0; x < 4; x++) img[y][x] = 1;
      run_frame(4, 4, 30, 40, 30, "solid");

      // empty ROI
      clear_img();
      run_frame(6, 3, 5, 5, 0, "empty");

      // R8: full-width single line with idle cycles
      clear_img();
      for (int x = 0; x < MAX_W; x++) img[0][x] = 1;
      run_frame(MAX_W, 1, 4000 - MAX_W, 4095, 40, "fullrow");

      // R8: one column, alternating pixels, full height
      clear_img();
      for (int y = 0; y < MAX_H; y += 2) img[y][0] = 1;
      run_frame(1, MAX_H, 4095, 1000, 10, "column");

      // R7: pixels offered while not busy have no effect
      begin
         longint a0, p0, e0;
         a0 = longint'(area); p0 = longint'(perimeter); e0 = longint'(euler);
         pix_valid = 1'b1; pix_fg = 1'b1;
         repeat (6) @(negedge clk);
         pix_valid = 1'b0; pix_fg = 1'b0;
         check(longint'(area) == a0, "R7", "idle area", longint'(area), a0);
         check(longint'(perimeter) == p0 && longint'(euler) == e0 && done,
               "R7", "idle perimeter/euler/done", longint'(perimeter), p0);
      end

      // random frames
      for (int f = 0; f < 30; f++) begin
         int w, h, dens;
         w = (f == 5) ? MAX_W : 1 + int'($urandom_range(19));
         h = (f == 9) ? MAX_H : 1 + int'($urandom_range(15));
         dens = 20 + int'($urandom_range(60));
         clear_img();
         for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
               img[y][x] = ($urandom_range(99) < dens);
         run_frame(w, h, int'($urandom_range(3000)), int'($urandom_range(3000)),
                   int'($urandom_range(30)), $sformatf("rand%0d", f));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule